// File: doc/BRIEF.md
# Type-C mux switch sequencer

This block takes a request for a new Type-C crossbar setting: a connection mode, a plug orientation and a low-power flag, written together with a one-cycle strobe. It first asks the USB and DisplayPort controllers to release the lanes they are using. It then waits until those lanes report a deep power state, and until the controllers acknowledge where that option is enabled. Only then does it drive the new mode and orientation onto the crossbar. The disable line can optionally be wrapped around the change as a transient safe state. It can also be left asserted after the change to park every lane in a low-power safe state.

The controller runs through six named states. IDLE captures a pending request and goes to REQ_DISABLE, which raises the controller disable requests. REQ_DISABLE always moves on to WAIT_LANES. WAIT_LANES stays put until the lanes and handshakes are ready, then moves to APPLY. APPLY always moves to RELEASE, RELEASE always moves to DONE, and DONE always returns to IDLE. A request written while a sequence is in flight is kept pending and runs once IDLE is reached again. A block-SuperSpeed output emulates an external switch that cuts the USB link whenever a USB-carrying mode is left.

Top module: `tcmux_seq`

## Requirements
- R1: After reset, xbar_mode is 2'b00, and xbar_flip, xbar_disable, xbar_reset, usb_dis_req, dp_dis_req, block_ss, req_valid and done are all 0.
- R2: A completed request drives its 2-bit mode onto xbar_mode, encoded as 00 none, 01 USB only, 10 DP on all lanes, 11 USB plus DP on the lower half of the DP lanes. USB lanes belong to modes 01 and 11.
- R3: xbar_flip takes the requested orientation (0 normal, 1 flipped) XOR the flip_inv input as sampled in the APPLY cycle.
- R4: While the applied mode uses USB or DP, no new setting is driven until every lane of that mode shows power state 2'b11 (P3) with its ack low. xbar_mode and xbar_flip change only on the edge that leaves APPLY, and the matching disable request (usb_dis_req, dp_dis_req) is held high during the wait.
- R5: With cfg_p2_en[0] (USB) or cfg_p2_en[1] (DP) set, that protocol's lanes are also accepted at power state 2'b10 (P2).
- R6: With cfg_hs_en[0] (USB) or cfg_hs_en[1] (DP) set, the sequence also waits for usb_dis_ack or dp_dis_ack respectively. Both disable requests are low when done is high.
- R7: With cfg_safe_en set, xbar_disable is high in the cycle where the mode or flip changes, and is low again when done is reported for a request without the low-power flag.
- R8: A request with the low-power flag leaves xbar_disable high after done. xbar_reset equals the flag AND cfg_rst_en at done.
- R9: block_ss is set when leaving mode 01 with cfg_blk_en[0] set, or leaving mode 11 with cfg_blk_en[1] set. It is cleared only by a completed request whose mode uses USB without the low-power flag.
- R10: cfg_ack_byp[0] (USB) or cfg_ack_byp[1] (DP) makes the sequence ignore a high lane ack for that protocol.
- R11: req_valid rises after a write and clears itself once IDLE captures the request. A write made during a sequence stays pending (last write wins) and runs after the current one completes.
- R12: done is a pulse of exactly one cycle, issued once per executed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr | input | 1 | Request write strobe |
| req_mode | input | 2 | Requested connection mode |
| req_flip | input | 1 | Requested orientation |
| req_lowpwr | input | 1 | Requested low-power safe state |
| req_valid | output | 1 | Request written and not yet captured |
| flip_inv | input | 1 | Inverts the applied orientation |
| cfg_safe_en | input | 1 | Transient safe state around a change |
| cfg_rst_en | input | 1 | Lane reset while in low-power state |
| cfg_hs_en | input | 2 | Controller acknowledge wait, bit0 USB, bit1 DP |
| cfg_p2_en | input | 2 | Accept P2, bit0 USB, bit1 DP |
| cfg_ack_byp | input | 2 | Ignore lane ack, bit0 USB, bit1 DP |
| cfg_blk_en | input | 2 | Auto block on leaving mode 01 (bit0) or 11 (bit1) |
| usb_pstate | input | 2*USB_LANES | Power state per USB lane |
| usb_ack | input | USB_LANES | Ack per USB lane |
| dp_pstate | input | 2*DP_LANES | Power state per DP lane |
| dp_ack | input | DP_LANES | Ack per DP lane |
| usb_dis_ack | input | 1 | USB controller disable acknowledge |
| dp_dis_ack | input | 1 | DP controller disable acknowledge |
| xbar_mode | output | 2 | Applied crossbar mode |
| xbar_flip | output | 1 | Applied crossbar orientation |
| xbar_disable | output | 1 | Crossbar disable / safe state |
| xbar_reset | output | 1 | Lane reset to the crossbar |
| usb_dis_req | output | 1 | Disable request to USB controller |
| dp_dis_req | output | 1 | Disable request to DP controller |
| block_ss | output | 1 | Blocks SuperSpeed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the configuration inputs, cfg_hs_en and cfg_safe_en in particular, stay constant from the capture of a request until its done pulse. They also assume that flip_inv does not move while a request is waiting to be applied. The stimulus changes these settings only between requests. The one exception is the enables under test for P2 acceptance and ack bypass: these are switched while the sequencer sits in WAIT_LANES, to release a deliberate stall, and no property depends on them.

// File: rtl/tcmux_pkg.sv
`timescale 1ns/1ps
package tcmux_pkg;

    localparam logic [1:0] MUX_NONE    = 2'b00;
    localparam logic [1:0] MUX_USB     = 2'b01;
    localparam logic [1:0] MUX_DP4     = 2'b10;
    localparam logic [1:0] MUX_USB_DP2 = 2'b11;

    localparam logic [1:0] PST_P2 = 2'b10;
    localparam logic [1:0] PST_P3 = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_DIS,
        S_WAIT_LANES,
        S_APPLY,
        S_RELEASE,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       flip;
        logic       lowpwr;
    } mux_req_t;

    function automatic logic mode_has_usb(input logic [1:0] m);
        return m[0];
    endfunction

    function automatic logic mode_has_dp(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/tcmux_req_hold.sv
`timescale 1ns/1ps
module tcmux_req_hold
    import tcmux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  mux_req_t wr_req,
    input  logic     take,
    output logic     pend,
    output mux_req_t held
);

    // A write always wins over a capture in the same cycle: the captured
    // copy is the older one, the new one stays pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            held <= '0;
        end else if (wr) begin
            pend <= 1'b1;
            held <= wr_req;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/tcmux_lane_gate.sv
`timescale 1ns/1ps
module tcmux_lane_gate
    import tcmux_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic [2*NUM_LANES-1:0] lane_pst,
    input  logic [NUM_LANES-1:0]   lane_ack,
    input  logic [NUM_LANES-1:0]   lane_mask,
    input  logic                   p2_ok,
    input  logic                   ack_bypass,
    output logic                   all_quiet
);

    logic [NUM_LANES-1:0] quiet;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [1:0] pst;
        logic       deep;
        assign pst      = lane_pst[2*i +: 2];
        assign deep     = (pst == PST_P3) || (p2_ok && (pst == PST_P2));
        assign quiet[i] = !lane_mask[i] || (deep && (ack_bypass || !lane_ack[i]));
    end

    assign all_quiet = &quiet;

endmodule

// File: rtl/tcmux_ctrl.sv
`timescale 1ns/1ps
module tcmux_ctrl
    import tcmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend,
    input  mux_req_t   held,
    input  logic       usb_quiet,
    input  logic       dp_quiet,
    input  logic       flip_inv,
    input  logic       cfg_safe_en,
    input  logic       cfg_rst_en,
    input  logic [1:0] cfg_hs_en,
    input  logic [1:0] cfg_blk_en,
    input  logic       usb_dis_ack,
    input  logic       dp_dis_ack,
    output logic       take,
    output seq_state_e state,
    output logic       tgt_lowpwr,
    output logic [1:0] xbar_mode,
    output logic       xbar_flip,
    output logic       xbar_disable,
    output logic       xbar_reset,
    output logic       usb_dis_req,
    output logic       dp_dis_req,
    output logic       block_ss,
    output logic       done
);

    seq_state_e nxt;
    mux_req_t   tgt;
    logic       usb_need;
    logic       dp_need;
    logic       usb_ready;
    logic       dp_ready;
    logic       lanes_ready;
    logic       leave_blk;

    assign usb_need    = mode_has_usb(xbar_mode);
    assign dp_need     = mode_has_dp(xbar_mode);
    assign usb_ready   = !usb_need || (usb_quiet && (!cfg_hs_en[0] || usb_dis_ack));
    assign dp_ready    = !dp_need  || (dp_quiet  && (!cfg_hs_en[1] || dp_dis_ack));
    assign lanes_ready = usb_ready && dp_ready;

    assign leave_blk = ((xbar_mode == MUX_USB)     && (held.mode != MUX_USB)     && cfg_blk_en[0]) ||
                       ((xbar_mode == MUX_USB_DP2) && (held.mode != MUX_USB_DP2) && cfg_blk_en[1]);

    assign take       = (state == S_IDLE) && pend;
    assign done       = (state == S_DONE);
    assign tgt_lowpwr = tgt.lowpwr;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (pend) nxt = S_REQ_DIS;
            S_REQ_DIS:    nxt = S_WAIT_LANES;
            S_WAIT_LANES: if (lanes_ready) nxt = S_APPLY;
            S_APPLY:      nxt = S_RELEASE;
            S_RELEASE:    nxt = S_DONE;
            S_DONE:       nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt          <= '0;
            xbar_mode    <= MUX_NONE;
            xbar_flip    <= 1'b0;
            xbar_disable <= 1'b0;
            xbar_reset   <= 1'b0;
            usb_dis_req  <= 1'b0;
            dp_dis_req   <= 1'b0;
            block_ss     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (pend) begin
                        tgt         <= held;
                        usb_dis_req <= usb_need;
                        dp_dis_req  <= dp_need;
                        if (leave_blk) block_ss <= 1'b1;
                    end
                end
                S_WAIT_LANES: begin
                    if (lanes_ready && (cfg_safe_en || tgt.lowpwr)) xbar_disable <= 1'b1;
                end
                S_APPLY: begin
                    xbar_mode <= tgt.mode;
                    xbar_flip <= tgt.flip ^ flip_inv;
                end
                S_RELEASE: begin
                    xbar_disable <= tgt.lowpwr;
                    xbar_reset   <= tgt.lowpwr && cfg_rst_en;
                    usb_dis_req  <= 1'b0;
                    dp_dis_req   <= 1'b0;
                    if (mode_has_usb(tgt.mode) && !tgt.lowpwr) block_ss <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tcmux_seq.sv
`timescale 1ns/1ps
module tcmux_seq
    import tcmux_pkg::*;
#(
    parameter int USB_LANES = 2,
    parameter int DP_LANES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_wr,
    input  logic [1:0]            req_mode,
    input  logic                  req_flip,
    input  logic                  req_lowpwr,
    output logic                  req_valid,
    input  logic                  flip_inv,
    input  logic                  cfg_safe_en,
    input  logic                  cfg_rst_en,
    input  logic [1:0]            cfg_hs_en,
    input  logic [1:0]            cfg_p2_en,
    input  logic [1:0]            cfg_ack_byp,
    input  logic [1:0]            cfg_blk_en,
    input  logic [2*USB_LANES-1:0] usb_pstate,
    input  logic [USB_LANES-1:0]  usb_ack,
    input  logic [2*DP_LANES-1:0] dp_pstate,
    input  logic [DP_LANES-1:0]   dp_ack,
    input  logic                  usb_dis_ack,
    input  logic                  dp_dis_ack,
    output logic [1:0]            xbar_mode,
    output logic                  xbar_flip,
    output logic                  xbar_disable,
    output logic                  xbar_reset,
    output logic                  usb_dis_req,
    output logic                  dp_dis_req,
    output logic                  block_ss,
    output logic                  done
);

    localparam int DP_HALF = DP_LANES / 2;

    mux_req_t             wr_req;
    mux_req_t             held;
    logic                 pend;
    logic                 take;
    seq_state_e           seq_state;
    logic                 tgt_lowpwr;
    logic                 usb_quiet;
    logic                 dp_quiet;
    logic [DP_LANES-1:0]  dp_mask;
    logic [USB_LANES-1:0] usb_mask;

    assign wr_req.mode   = req_mode;
    assign wr_req.flip   = req_flip;
    assign wr_req.lowpwr = req_lowpwr;
    assign req_valid     = pend;
    assign usb_mask      = '1;

    for (genvar i = 0; i < DP_LANES; i++) begin : g_dp_mask
        assign dp_mask[i] = (xbar_mode == MUX_DP4) ||
                            ((xbar_mode == MUX_USB_DP2) && (i < DP_HALF));
    end

    tcmux_req_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (req_wr),
        .wr_req (wr_req),
        .take   (take),
        .pend   (pend),
        .held   (held)
    );

    tcmux_lane_gate #(.NUM_LANES(USB_LANES)) u_usb_gate (
        .lane_pst   (usb_pstate),
        .lane_ack   (usb_ack),
        .lane_mask  (usb_mask),
        .p2_ok      (cfg_p2_en[0]),
        .ack_bypass (cfg_ack_byp[0]),
        .all_quiet  (usb_quiet)
    );

    tcmux_lane_gate #(.NUM_LANES(DP_LANES)) u_dp_gate (
        .lane_pst   (dp_pstate),
        .lane_ack   (dp_ack),
        .lane_mask  (dp_mask),
        .p2_ok      (cfg_p2_en[1]),
        .ack_bypass (cfg_ack_byp[1]),
        .all_quiet  (dp_quiet)
    );

    tcmux_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend         (pend),
        .held         (held),
        .usb_quiet    (usb_quiet),
        .dp_quiet     (dp_quiet),
        .flip_inv     (flip_inv),
        .cfg_safe_en  (cfg_safe_en),
        .cfg_rst_en   (cfg_rst_en),
        .cfg_hs_en    (cfg_hs_en),
        .cfg_blk_en   (cfg_blk_en),
        .usb_dis_ack  (usb_dis_ack),
        .dp_dis_ack   (dp_dis_ack),
        .take         (take),
        .state        (seq_state),
        .tgt_lowpwr   (tgt_lowpwr),
        .xbar_mode    (xbar_mode),
        .xbar_flip    (xbar_flip),
        .xbar_disable (xbar_disable),
        .xbar_reset   (xbar_reset),
        .usb_dis_req  (usb_dis_req),
        .dp_dis_req   (dp_dis_req),
        .block_ss     (block_ss),
        .done         (done)
    );

endmodule

// File: rtl/tcmux_seq_chk.sv
`timescale 1ns/1ps
module tcmux_seq_chk
    import tcmux_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input seq_state_e state,
    input logic       req_wr,
    input logic       req_valid,
    input logic [1:0] xbar_mode,
    input logic       xbar_flip,
    input logic       xbar_disable,
    input logic       done,
    input logic       cfg_safe_en,
    input logic [1:0] cfg_hs_en,
    input logic       usb_dis_req,
    input logic       usb_dis_ack,
    input logic       dp_dis_req,
    input logic       dp_dis_ack,
    input logic       tgt_lowpwr
);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_change_after_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(xbar_mode) || !$stable(xbar_flip)) |-> ($past(state) == S_APPLY));

    p_safe_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(xbar_mode) && $past(cfg_safe_en)) |-> $past(xbar_disable));

    p_usb_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_APPLY && $past(cfg_hs_en[0] && usb_dis_req)) |-> $past(usb_dis_ack));

    p_dp_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_APPLY && $past(cfg_hs_en[1] && dp_dis_req)) |-> $past(dp_dis_ack));

    p_req_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!usb_dis_req && !dp_dis_req));

    p_lowpwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xbar_disable == tgt_lowpwr));

    p_valid_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid && !req_wr) |=> !req_valid);

    p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && req_valid) |=> req_valid);

endmodule

bind tcmux_seq tcmux_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (seq_state),
    .req_wr       (req_wr),
    .req_valid    (req_valid),
    .xbar_mode    (xbar_mode),
    .xbar_flip    (xbar_flip),
    .xbar_disable (xbar_disable),
    .done         (done),
    .cfg_safe_en  (cfg_safe_en),
    .cfg_hs_en    (cfg_hs_en),
    .usb_dis_req  (usb_dis_req),
    .usb_dis_ack  (usb_dis_ack),
    .dp_dis_req   (dp_dis_req),
    .dp_dis_ack   (dp_dis_ack),
    .tgt_lowpwr   (tgt_lowpwr)
);

// File: tb/tb_tcmux_seq.sv
`timescale 1ns/1ps
module tb_tcmux_seq;

    localparam int USB_LANES = 2;
    localparam int DP_LANES  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wr = 1'b0;
    logic [1:0] req_mode = 2'b00;
    logic req_flip = 1'b0;
    logic req_lowpwr = 1'b0;
    logic req_valid;
    logic flip_inv = 1'b0;
    logic cfg_safe_en = 1'b0;
    logic cfg_rst_en = 1'b0;
    logic [1:0] cfg_hs_en = 2'b00;
    logic [1:0] cfg_p2_en = 2'b00;
    logic [1:0] cfg_ack_byp = 2'b00;
    logic [1:0] cfg_blk_en = 2'b00;
    logic [2*USB_LANES-1:0] usb_pstate = '1;
    logic [USB_LANES-1:0] usb_ack = '0;
    logic [2*DP_LANES-1:0] dp_pstate = '1;
    logic [DP_LANES-1:0] dp_ack = '0;
    logic usb_dis_ack = 1'b0;
    logic dp_dis_ack = 1'b0;
    logic [1:0] xbar_mode;
    logic xbar_flip, xbar_disable, xbar_reset, usb_dis_req, dp_dis_req, block_ss, done;

    always #10 clk = ~clk;

    tcmux_seq #(.USB_LANES(USB_LANES), .DP_LANES(DP_LANES)) dut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mode(req_mode),
        .req_flip(req_flip), .req_lowpwr(req_lowpwr), .req_valid(req_valid),
        .flip_inv(flip_inv), .cfg_safe_en(cfg_safe_en), .cfg_rst_en(cfg_rst_en),
        .cfg_hs_en(cfg_hs_en), .cfg_p2_en(cfg_p2_en), .cfg_ack_byp(cfg_ack_byp),
        .cfg_blk_en(cfg_blk_en), .usb_pstate(usb_pstate), .usb_ack(usb_ack),
        .dp_pstate(dp_pstate), .dp_ack(dp_ack), .usb_dis_ack(usb_dis_ack),
        .dp_dis_ack(dp_dis_ack), .xbar_mode(xbar_mode), .xbar_flip(xbar_flip),
        .xbar_disable(xbar_disable), .xbar_reset(xbar_reset),
        .usb_dis_req(usb_dis_req), .dp_dis_req(dp_dis_req),
        .block_ss(block_ss), .done(done)
    );

    typedef struct {
        logic [1:0] mode;
        logic       flip;
        logic       dis;
        logic       rst;
        logic       blk;
        logic       chg_chk;
        logic       chg_dis;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int n_issued = 0;
    logic [1:0] model_mode = 2'b00;
    logic model_flip = 1'b0;
    logic model_blk = 1'b0;
    logic [1:0] pm = 2'b00;
    logic pf = 1'b0;
    logic pdone = 1'b0;
    logic chg_seen = 1'b0;
    logic chg_dis = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: writes a request and pushes what the requirements predict.
    task automatic issue(input logic [1:0] m, input logic f, input logic lp, input string tag);
        exp_t e;
        e.mode = m;
        e.flip = f ^ flip_inv;
        e.dis  = lp;
        e.rst  = lp & cfg_rst_en;
        if (((model_mode == 2'b01) && (m != 2'b01) && cfg_blk_en[0]) ||
            ((model_mode == 2'b11) && (m != 2'b11) && cfg_blk_en[1])) model_blk = 1'b1;
        if (m[0] && !lp) model_blk = 1'b0;
        e.blk     = model_blk;
        e.chg_chk = (m != model_mode) || (e.flip != model_flip);
        e.chg_dis = cfg_safe_en | lp;
        e.tag     = tag;
        model_mode = m;
        model_flip = e.flip;
        sb.push_back(e);
        n_issued++;
        @(negedge clk);
        req_wr = 1'b1; req_mode = m; req_flip = f; req_lowpwr = lp;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cnt < n_issued; i++) @(negedge clk);
        chk(done_cnt == n_issued, "R12", "completions", done_cnt, n_issued);
        @(negedge clk);
    endtask

    task automatic expect_stall(input string req);
        int d0;
        d0 = done_cnt;
        repeat (20) @(negedge clk);
        chk(done_cnt == d0, req, "stall completions", done_cnt, d0);
        chk(xbar_mode == pm, req, "mode held", int'(xbar_mode), int'(pm));
    endtask

    // Monitor: pops expected items on every done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((xbar_mode != pm) || (xbar_flip != pf)) begin
                chg_seen = 1'b1;
                chg_dis  = xbar_disable;
            end
            pm = xbar_mode;
            pf = xbar_flip;
            if (done && pdone) chk(0, "R12", "done width", 2, 1);
            if (done) begin
                done_cnt++;
                if (sb.size() == 0) begin
                    chk(0, "R12", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(xbar_mode == e.mode, "R2", {e.tag, " mode"}, int'(xbar_mode), int'(e.mode));
                    chk(xbar_flip == e.flip, "R3", {e.tag, " flip"}, int'(xbar_flip), int'(e.flip));
                    chk(xbar_disable == e.dis, "R8", {e.tag, " disable"}, int'(xbar_disable), int'(e.dis));
                    chk(xbar_reset == e.rst, "R8", {e.tag, " reset"}, int'(xbar_reset), int'(e.rst));
                    chk(block_ss == e.blk, "R9", {e.tag, " block_ss"}, int'(block_ss), int'(e.blk));
                    chk(!usb_dis_req && !dp_dis_req, "R6", {e.tag, " reqs dropped"},
                        int'({usb_dis_req, dp_dis_req}), 0);
                    if (e.chg_chk)
                        chk(chg_seen && (chg_dis == e.chg_dis), "R7", {e.tag, " disable at change"},
                            int'({chg_seen, chg_dis}), int'({1'b1, e.chg_dis}));
                end
                chg_seen = 1'b0;
            end
            pdone = done;
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(xbar_mode == 2'b00, "R1", "mode", int'(xbar_mode), 0);
        chk({xbar_flip, xbar_disable, xbar_reset} == 3'b000, "R1", "xbar bits",
            int'({xbar_flip, xbar_disable, xbar_reset}), 0);
        chk({usb_dis_req, dp_dis_req, block_ss, req_valid, done} == 5'b0, "R1", "misc",
            int'({usb_dis_req, dp_dis_req, block_ss, req_valid, done}), 0);

        // R2 plain USB request from no connection
        issue(2'b01, 1'b0, 1'b0, "R2 usb");
        wait_done();

        // R3 flip inverted
        flip_inv = 1'b1;
        issue(2'b11, 1'b1, 1'b0, "R3 usbdp flip");
        wait_done();

        // R4 stall on P0, still stall on P2, R5 released by P2 enable
        usb_pstate[1:0] = 2'b00;
        issue(2'b10, 1'b0, 1'b0, "R5 dp4");
        expect_stall("R4");
        chk(usb_dis_req == 1'b1, "R4", "usb disable request", int'(usb_dis_req), 1);
        usb_pstate[1:0] = 2'b10;
        expect_stall("R4");
        cfg_p2_en = 2'b01;
        wait_done();
        usb_pstate = '1; cfg_p2_en = 2'b00; flip_inv = 1'b0;

        // R6 DP handshake
        cfg_hs_en = 2'b10;
        issue(2'b01, 1'b1, 1'b0, "R6 hs");
        expect_stall("R6");
        chk(dp_dis_req == 1'b1, "R6", "dp disable request", int'(dp_dis_req), 1);
        dp_dis_ack = 1'b1;
        wait_done();
        dp_dis_ack = 1'b0; cfg_hs_en = 2'b00;

        // R7 transient safe state
        cfg_safe_en = 1'b1;
        issue(2'b11, 1'b0, 1'b0, "R7 safe");
        wait_done();
        cfg_safe_en = 1'b0;

        // R9 block on leaving USB+DP
        cfg_blk_en = 2'b10;
        issue(2'b10, 1'b0, 1'b0, "R9 block");
        wait_done();
        chk(block_ss == 1'b1, "R9", "block after leave", int'(block_ss), 1);

        // R10 ack bypass for DP
        dp_ack[3] = 1'b1;
        issue(2'b00, 1'b0, 1'b0, "R10 byp");
        expect_stall("R10");
        cfg_ack_byp = 2'b10;
        wait_done();
        dp_ack = '0; cfg_ack_byp = 2'b00;

        // R8 low power parks the crossbar, block stays
        cfg_rst_en = 1'b1;
        issue(2'b01, 1'b0, 1'b1, "R8 lowpwr");
        wait_done();
        issue(2'b01, 1'b0, 1'b0, "R8 wake");
        wait_done();
        cfg_rst_en = 1'b0; cfg_blk_en = 2'b00;

        // R11 held request
        usb_pstate[1:0] = 2'b00;
        issue(2'b10, 1'b0, 1'b0, "R11 first");
        repeat (5) @(negedge clk);
        chk(req_valid == 1'b0, "R11", "valid self clear", int'(req_valid), 0);
        issue(2'b11, 1'b1, 1'b0, "R11 second");
        chk(req_valid == 1'b1, "R11", "valid while busy", int'(req_valid), 1);
        repeat (10) @(negedge clk);
        chk(req_valid == 1'b1, "R11", "valid held", int'(req_valid), 1);
        chk(xbar_mode == 2'b01, "R11", "first stalled", int'(xbar_mode), 1);
        usb_pstate = '1;
        wait_done();
        chk(req_valid == 1'b0, "R11", "valid after both", int'(req_valid), 0);
        chk(sb.size() == 0, "R12", "scoreboard empty", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule